// File: doc/BRIEF.md
# Power Fault and Reset Sequencer

This block runs from the always-on 32 kHz clock and selects the operating mode of a metering chip's digital section. It watches an external reset pin, a comparator flag that is high while system power is above threshold, and a battery-good flag. From these it decides when the digital core wakes and when the processor starts at address zero. It also decides whether the chip runs at full power (MISSION), on battery with the processor alive (BROWNOUT), in display-only (LCD) or fully asleep (SLEEP). When power returns, the path back to full power depends on where the chip was. From BROWNOUT the configuration is kept and an interrupt is raised. From LCD or SLEEP the configuration has already been cleared, so the processor boots again.

The reset pin, the comparator and the battery flag are asynchronous. Each goes through a two-flop synchronizer, so the state machine acts on a change of any of them on the third rising clock edge after it. The PLL lock flag and the two low-power requests are synchronous to the clock.

After power returns, a lock counter holds the chip out of MISSION. The wait ends when the lock flag is seen once at least the minimum number of cycles has passed, or when the maximum is reached, whichever comes first. A parameter can force a fixed wait instead.

Top module: `pwr_seq_top`

## Requirements
- R1: While the synchronized reset pin is high, wake, pll_ok and wdt_en are 0 and mode reads SLEEP (2'b11). On the first cycle the assertion is seen, cfg_clr pulses for exactly one cycle. The response appears on the third rising edge after the pin changes.
- R2: When reset is released with system power present, wake stays low for HOLD_PWR cycles (default 4100) after the release is seen. Wake then rises, mode becomes MISSION (2'b00), pll_ok rises and mpu_start pulses for one cycle.
- R3: When reset is released with system power absent, the hold is HOLD_BAT cycles (default 2). Wake then rises in BROWNOUT (2'b01) with pll_ok low, and mpu_start pulses for one cycle.
- R4: If power drops in MISSION with the battery good, pll_ok clears and mode becomes BROWNOUT on the same edge. Wake stays high and cfg_clr does not pulse.
- R5: If power drops in MISSION with the battery bad, mode becomes SLEEP, wake falls and cfg_clr pulses for one cycle.
- R6: Once power is back and mode is not MISSION, mode stays where it is until the power-present cycle count n reaches LOCK_MIN with pll_lock high, or reaches LOCK_MAX. Mode then turns to MISSION with pll_ok high. A power drop during the wait restarts the count.
- R7: A BROWNOUT to MISSION change gives a one-cycle mode_irq pulse. It gives no cfg_clr and no mpu_start.
- R8: An LCD or SLEEP to MISSION change raises wake and gives a one-cycle mpu_start pulse, with no mode_irq.
- R9: wdt_en rises only on the edge that enters MISSION and is low in every other mode.
- R10: In BROWNOUT without power, sleep_req (first priority) moves to SLEEP and lcd_req moves to LCD (2'b10). Either one drops wake and pulses cfg_clr. In LCD, sleep_req moves to SLEEP. Both requests have no effect in MISSION.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on 32 kHz clock |
| arst_n | input | 1 | Power-on reset of the always-on domain, active low |
| rst_pin | input | 1 | External reset pin, asynchronous, active high |
| pwr_ok | input | 1 | Power comparator output, asynchronous, 1 = power above threshold |
| bat_ok | input | 1 | Battery-good flag, asynchronous |
| pll_lock | input | 1 | PLL lock indication, synchronous |
| lcd_req | input | 1 | Request for display-only mode, synchronous |
| sleep_req | input | 1 | Request for sleep mode, synchronous |
| wake | output | 1 | Digital section awake |
| pll_ok | output | 1 | PLL ready status |
| mode | output | 2 | 00 MISSION, 01 BROWNOUT, 10 LCD, 11 SLEEP |
| cfg_clr | output | 1 | One-cycle strobe that returns configuration to defaults |
| mode_irq | output | 1 | One-cycle interrupt on BROWNOUT to MISSION |
| mpu_start | output | 1 | One-cycle strobe: processor starts at address zero |
| wdt_en | output | 1 | Hardware watchdog enable |

## Verification
A stuck or miscounted hold counter shows up as wake rising at the wrong edge. A lock counter that does not restart after a power glitch shows up as MISSION being entered early. Each such case is pinned to one exact cycle, with the edge before it checked as well. A mode register that tracks the wrong origin swaps mode_irq and mpu_start when MISSION is entered. This is visible on that same edge, and cfg_clr shows a lost or extra configuration clear within one cycle of the mode change.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    M_MISSION  = 2'b00,
    M_BROWNOUT = 2'b01,
    M_LCD      = 2'b10,
    M_SLEEP    = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    PH_RESET = 2'b00,
    PH_HOLD  = 2'b01,
    PH_RUN   = 2'b10
  } phase_e;

  // hold length chosen by the power state latched at reset release
  function automatic int unsigned hold_cycles(logic pwr_at_rel,
                                              int unsigned with_pwr,
                                              int unsigned no_pwr);
    return pwr_at_rel ? with_pwr : no_pwr;
  endfunction

  // n = power-present cycles seen so far, including the current one
  function automatic logic lock_done(int unsigned n, logic lock,
                                     int unsigned lo, int unsigned hi,
                                     int unsigned fixed);
    if (fixed != 0) return (n >= fixed);
    return ((n >= lo) && lock) || (n >= hi);
  endfunction

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pwr_seq_ctr.sv
module pwr_seq_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)  cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned HOLD_PWR   = 4100,
  parameter int unsigned HOLD_BAT   = 2,
  parameter int unsigned LOCK_MIN   = 2048,
  parameter int unsigned LOCK_MAX   = 4096,
  parameter int unsigned LOCK_FIXED = 0
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       rst_s,
  input  logic       pwr_s,
  input  logic       bat_s,
  input  logic       pll_lock,
  input  logic       lcd_req,
  input  logic       sleep_req,
  output logic       wake,
  output logic       pll_ok,
  output logic [1:0] mode,
  output logic       cfg_clr,
  output logic       mode_irq,
  output logic       mpu_start,
  output logic       wdt_en
);
  localparam int unsigned HOLD_MAX = (HOLD_PWR > HOLD_BAT) ? HOLD_PWR : HOLD_BAT;
  localparam int HW = $clog2(HOLD_MAX + 1);
  localparam int LW = $clog2(LOCK_MAX + 1);

  phase_e phase_q, phase_d;
  mode_e  mode_q, mode_d;
  logic   wake_q, wake_d, pll_q, pll_d, wdt_q, wdt_d;
  logic   cfg_q, cfg_d, irq_q, irq_d, start_q, start_d;
  logic   relpwr_q, relpwr_d;

  logic [HW-1:0] hold_cnt;
  logic [LW-1:0] lock_cnt;

  // named internal events
  logic in_hold, hold_fire, lock_wait, lock_fire;

  assign in_hold   = (phase_q == PH_HOLD) && !rst_s;
  assign hold_fire = in_hold &&
                     ((32'(hold_cnt) + 1) >= hold_cycles(relpwr_q, HOLD_PWR, HOLD_BAT));
  assign lock_wait = !rst_s && (phase_q == PH_RUN) && (mode_q != M_MISSION) && pwr_s;
  assign lock_fire = lock_wait &&
                     lock_done(32'(lock_cnt) + 1, pll_lock, LOCK_MIN, LOCK_MAX, LOCK_FIXED);

  pwr_seq_ctr #(.W(HW)) u_hold_ctr (
    .clk(clk), .arst_n(arst_n), .clr(!in_hold), .en(in_hold), .cnt(hold_cnt)
  );

  pwr_seq_ctr #(.W(LW)) u_lock_ctr (
    .clk(clk), .arst_n(arst_n), .clr(!lock_wait), .en(lock_wait), .cnt(lock_cnt)
  );

  always_comb begin
    phase_d  = phase_q;
    mode_d   = mode_q;
    wake_d   = wake_q;
    pll_d    = pll_q;
    wdt_d    = wdt_q;
    relpwr_d = relpwr_q;
    cfg_d    = 1'b0;
    irq_d    = 1'b0;
    start_d  = 1'b0;
    if (rst_s) begin
      if (phase_q != PH_RESET) cfg_d = 1'b1;
      phase_d = PH_RESET;
      mode_d  = M_SLEEP;
      wake_d  = 1'b0;
      pll_d   = 1'b0;
      wdt_d   = 1'b0;
    end else begin
      case (phase_q)
        PH_RESET: begin
          phase_d  = PH_HOLD;
          relpwr_d = pwr_s;
        end
        PH_HOLD: begin
          if (hold_fire) begin
            phase_d = PH_RUN;
            wake_d  = 1'b1;
            start_d = 1'b1;
            if (relpwr_q) begin
              mode_d = M_MISSION;
              pll_d  = 1'b1;
              wdt_d  = 1'b1;
            end else begin
              mode_d = M_BROWNOUT;
            end
          end
        end
        default: begin
          if (mode_q == M_MISSION) begin
            if (!pwr_s) begin
              pll_d = 1'b0;
              wdt_d = 1'b0;
              if (bat_s) begin
                mode_d = M_BROWNOUT;
              end else begin
                mode_d = M_SLEEP;
                wake_d = 1'b0;
                cfg_d  = 1'b1;
              end
            end
          end else if (lock_fire) begin
            mode_d = M_MISSION;
            wake_d = 1'b1;
            pll_d  = 1'b1;
            wdt_d  = 1'b1;
            if (mode_q == M_BROWNOUT) irq_d = 1'b1;
            else                      start_d = 1'b1;
          end else if (!pwr_s) begin
            if (mode_q == M_BROWNOUT) begin
              if (!bat_s || sleep_req) begin
                mode_d = M_SLEEP;
                wake_d = 1'b0;
                cfg_d  = 1'b1;
              end else if (lcd_req) begin
                mode_d = M_LCD;
                wake_d = 1'b0;
                cfg_d  = 1'b1;
              end
            end else if ((mode_q == M_LCD) && sleep_req) begin
              mode_d = M_SLEEP;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase_q  <= PH_RESET;
      mode_q   <= M_SLEEP;
      wake_q   <= 1'b0;
      pll_q    <= 1'b0;
      wdt_q    <= 1'b0;
      cfg_q    <= 1'b0;
      irq_q    <= 1'b0;
      start_q  <= 1'b0;
      relpwr_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      mode_q   <= mode_d;
      wake_q   <= wake_d;
      pll_q    <= pll_d;
      wdt_q    <= wdt_d;
      cfg_q    <= cfg_d;
      irq_q    <= irq_d;
      start_q  <= start_d;
      relpwr_q <= relpwr_d;
    end
  end

  assign wake      = wake_q;
  assign pll_ok    = pll_q;
  assign mode      = mode_q;
  assign cfg_clr   = cfg_q;
  assign mode_irq  = irq_q;
  assign mpu_start = start_q;
  assign wdt_en    = wdt_q;

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!arst_n)
    rst_s |=> (!wake_q && !wdt_q && !irq_q && !start_q && mode_q == M_SLEEP));

  // R4
  pll_drop_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (phase_q == PH_RUN && mode_q == M_MISSION && !pwr_s) |=> (!pll_q && mode_q != M_MISSION));

  // R5
  wake_lowpwr_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_q == M_LCD || mode_q == M_SLEEP) |-> !wake_q);

  // R7
  irq_origin_chk: assert property (@(posedge clk) disable iff (!arst_n)
    irq_q |-> (mode_q == M_MISSION && $past(mode_q) == M_BROWNOUT));

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!arst_n)
    irq_q |=> !irq_q);

  // R8
  clr_irq_excl_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !(cfg_q && irq_q));

  // R9
  wdt_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(wdt_q) |-> (mode_q == M_MISSION && $past(mode_q) != M_MISSION));

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top #(
  parameter int unsigned HOLD_PWR   = 4100,
  parameter int unsigned HOLD_BAT   = 2,
  parameter int unsigned LOCK_MIN   = 2048,
  parameter int unsigned LOCK_MAX   = 4096,
  parameter int unsigned LOCK_FIXED = 0
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       rst_pin,
  input  logic       pwr_ok,
  input  logic       bat_ok,
  input  logic       pll_lock,
  input  logic       lcd_req,
  input  logic       sleep_req,
  output logic       wake,
  output logic       pll_ok,
  output logic [1:0] mode,
  output logic       cfg_clr,
  output logic       mode_irq,
  output logic       mpu_start,
  output logic       wdt_en
);
  localparam int NSYNC = 3;
  // reset bit starts asserted, power and battery start absent
  localparam logic [NSYNC-1:0] SYNC_INIT = 3'b100;

  logic [NSYNC-1:0] raw_in, syn_out;

  assign raw_in = {rst_pin, pwr_ok, bat_ok};

  pwr_seq_sync #(.W(NSYNC), .RST_VAL(SYNC_INIT)) u_sync (
    .clk(clk), .arst_n(arst_n), .d(raw_in), .q(syn_out)
  );

  pwr_seq_fsm #(
    .HOLD_PWR(HOLD_PWR), .HOLD_BAT(HOLD_BAT),
    .LOCK_MIN(LOCK_MIN), .LOCK_MAX(LOCK_MAX), .LOCK_FIXED(LOCK_FIXED)
  ) u_fsm (
    .clk(clk), .arst_n(arst_n),
    .rst_s(syn_out[2]), .pwr_s(syn_out[1]), .bat_s(syn_out[0]),
    .pll_lock(pll_lock), .lcd_req(lcd_req), .sleep_req(sleep_req),
    .wake(wake), .pll_ok(pll_ok), .mode(mode), .cfg_clr(cfg_clr),
    .mode_irq(mode_irq), .mpu_start(mpu_start), .wdt_en(wdt_en)
  );
endmodule

// File: tb/tb_pwr_seq_top.sv
`timescale 1ns/1ps
module tb_pwr_seq_top;
  localparam int HP = 20, HB = 2, LMIN = 8, LMAX = 16;
  localparam int S_WAKE = 0, S_PLL = 1, S_MODE = 2, S_CFG = 3,
                 S_IRQ = 4, S_START = 5, S_WDT = 6;

  logic clk = 0;
  logic arst_n, rst_pin, pwr_ok, bat_ok, pll_lock, lcd_req, sleep_req;
  logic wake, pll_ok, cfg_clr, mode_irq, mpu_start, wdt_en;
  logic [1:0] mode;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int    at;
    int    sel;
    int    val;
    string req;
  } exp_t;
  exp_t sbq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_seq_top #(.HOLD_PWR(HP), .HOLD_BAT(HB), .LOCK_MIN(LMIN), .LOCK_MAX(LMAX),
                .LOCK_FIXED(0)) dut (
    .clk(clk), .arst_n(arst_n), .rst_pin(rst_pin), .pwr_ok(pwr_ok), .bat_ok(bat_ok),
    .pll_lock(pll_lock), .lcd_req(lcd_req), .sleep_req(sleep_req),
    .wake(wake), .pll_ok(pll_ok), .mode(mode), .cfg_clr(cfg_clr),
    .mode_irq(mode_irq), .mpu_start(mpu_start), .wdt_en(wdt_en)
  );

  function automatic int probe(int sel);
    case (sel)
      S_WAKE:  return int'(wake);
      S_PLL:   return int'(pll_ok);
      S_MODE:  return int'(mode);
      S_CFG:   return int'(cfg_clr);
      S_IRQ:   return int'(mode_irq);
      S_START: return int'(mpu_start);
      default: return int'(wdt_en);
    endcase
  endfunction

  function automatic string sname(int sel);
    case (sel)
      S_WAKE:  return "wake";
      S_PLL:   return "pll_ok";
      S_MODE:  return "mode";
      S_CFG:   return "cfg_clr";
      S_IRQ:   return "mode_irq";
      S_START: return "mpu_start";
      default: return "wdt_en";
    endcase
  endfunction

  // driver side: expectation 'off' negedges from now
  task automatic expect_at(int off, int sel, int val, string req);
    sbq.push_back('{cyc + off, sel, val, req});
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].at == cyc) begin
        checks++;
        if (probe(sbq[i].sel) != sbq[i].val) begin
          errors++;
          $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", sbq[i].req,
                   sname(sbq[i].sel), probe(sbq[i].sel), sbq[i].val, cyc);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic power_cycle_to_brownout();
    pwr_ok = 0;
    step(6);
  endtask

  initial begin
    arst_n = 0; rst_pin = 0; pwr_ok = 1; bat_ok = 1; pll_lock = 1;
    lcd_req = 0; sleep_req = 0;
    step(3);
    arst_n = 1;
    // R1 reset state, then R2 hold with power
    expect_at(1, S_WAKE, 0, "R1");
    expect_at(1, S_MODE, 3, "R1");
    expect_at(1, S_WDT, 0, "R1");
    expect_at(1, S_PLL, 0, "R1");
    expect_at(HP + 2, S_WAKE, 0, "R2");
    expect_at(HP + 3, S_WAKE, 1, "R2");
    expect_at(HP + 3, S_MODE, 0, "R2");
    expect_at(HP + 3, S_PLL, 1, "R2");
    expect_at(HP + 3, S_START, 1, "R2");
    expect_at(HP + 4, S_START, 0, "R2");
    expect_at(HP + 3, S_WDT, 1, "R9");
    step(HP + 8);

    // R4 power fall, battery good
    pwr_ok = 0;
    expect_at(2, S_MODE, 0, "R4");
    expect_at(2, S_PLL, 1, "R4");
    expect_at(3, S_MODE, 1, "R4");
    expect_at(3, S_PLL, 0, "R4");
    expect_at(3, S_WAKE, 1, "R4");
    expect_at(3, S_CFG, 0, "R4");
    expect_at(3, S_WDT, 0, "R9");
    step(6);

    // R6/R7 return with lock held: minimum wait
    pwr_ok = 1;
    expect_at(LMIN + 1, S_MODE, 1, "R6");
    expect_at(LMIN + 2, S_MODE, 0, "R7");
    expect_at(LMIN + 2, S_PLL, 1, "R6");
    expect_at(LMIN + 2, S_IRQ, 1, "R7");
    expect_at(LMIN + 3, S_IRQ, 0, "R7");
    expect_at(LMIN + 2, S_CFG, 0, "R7");
    expect_at(LMIN + 2, S_START, 0, "R7");
    expect_at(LMIN + 2, S_WDT, 1, "R9");
    step(LMIN + 6);

    // R6 no lock: maximum wait
    power_cycle_to_brownout();
    pll_lock = 0;
    pwr_ok = 1;
    expect_at(LMAX + 1, S_MODE, 1, "R6");
    expect_at(LMAX + 2, S_MODE, 0, "R6");
    expect_at(LMAX + 2, S_IRQ, 1, "R7");
    step(LMAX + 6);

    // R6 lock arrives after the minimum
    power_cycle_to_brownout();
    pwr_ok = 1;
    expect_at(11, S_MODE, 1, "R6");
    step(11);
    pll_lock = 1;
    expect_at(1, S_MODE, 0, "R6");
    expect_at(1, S_IRQ, 1, "R7");
    step(6);

    // R6 glitch: power drops during the wait, no early entry
    power_cycle_to_brownout();
    pwr_ok = 1;
    step(4);
    pwr_ok = 0;
    expect_at(10, S_MODE, 1, "R6");
    expect_at(10, S_PLL, 0, "R6");
    step(12);

    // R10 LCD then SLEEP requests in brownout
    lcd_req = 1;
    expect_at(1, S_MODE, 2, "R10");
    expect_at(1, S_WAKE, 0, "R10");
    expect_at(1, S_CFG, 1, "R10");
    expect_at(2, S_CFG, 0, "R10");
    step(1);
    lcd_req = 0;
    step(3);
    sleep_req = 1;
    expect_at(1, S_MODE, 3, "R10");
    expect_at(1, S_CFG, 0, "R10");
    step(1);
    sleep_req = 0;
    step(2);

    // R8 return from SLEEP
    pwr_ok = 1;
    expect_at(LMIN + 2, S_MODE, 0, "R8");
    expect_at(LMIN + 2, S_WAKE, 1, "R8");
    expect_at(LMIN + 2, S_START, 1, "R8");
    expect_at(LMIN + 2, S_IRQ, 0, "R8");
    expect_at(LMIN + 3, S_START, 0, "R8");
    step(LMIN + 6);

    // R10 requests ignored in MISSION
    lcd_req = 1; sleep_req = 1;
    expect_at(1, S_MODE, 0, "R10");
    expect_at(2, S_WAKE, 1, "R10");
    expect_at(2, S_CFG, 0, "R10");
    step(2);
    lcd_req = 0; sleep_req = 0;
    step(2);

    // R5 power fall, battery bad
    bat_ok = 0; pwr_ok = 0;
    expect_at(3, S_MODE, 3, "R5");
    expect_at(3, S_WAKE, 0, "R5");
    expect_at(3, S_CFG, 1, "R5");
    expect_at(4, S_CFG, 0, "R5");
    expect_at(3, S_PLL, 0, "R5");
    step(6);
    bat_ok = 1; pwr_ok = 1;
    expect_at(LMIN + 2, S_MODE, 0, "R8");
    expect_at(LMIN + 2, S_START, 1, "R8");
    step(LMIN + 6);

    // R1 reset pin in MISSION
    rst_pin = 1;
    expect_at(3, S_WAKE, 0, "R1");
    expect_at(3, S_MODE, 3, "R1");
    expect_at(3, S_CFG, 1, "R1");
    expect_at(4, S_CFG, 0, "R1");
    expect_at(3, S_WDT, 0, "R1");
    step(8);
    // R3 release without power
    pwr_ok = 0;
    step(6);
    rst_pin = 0;
    expect_at(HB + 2, S_WAKE, 0, "R3");
    expect_at(HB + 3, S_WAKE, 1, "R3");
    expect_at(HB + 3, S_MODE, 1, "R3");
    expect_at(HB + 3, S_START, 1, "R3");
    expect_at(HB + 3, S_PLL, 0, "R3");
    expect_at(HB + 3, S_WDT, 0, "R9");
    step(HB + 8);

    if (sbq.size() != 0) begin
      errors += sbq.size();
      $display("FAIL scoreboard %0d expectations never compared actual=%0d expected=0",
               sbq.size(), sbq.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog run hung actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule